// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between a 32-bit little-endian data memory port and the register file of a simple load/store pipeline stage. It looks at the control fields of a load/store instruction word and the two low address bits. For a load it turns the raw memory word into the value to write back. For a store it turns the source register into lane-placed store data and per-byte write enables. Address generation, base-register writeback and the memory itself are handled elsewhere.

A word load at an address that is not word aligned does not fault and is not split into two accesses. The fetched word is rotated right by eight bits for each step of misalignment. Byte loads are zero-extended. The block also raises two flags for register combinations that the pipeline must treat specially. One marks combinations whose result is unpredictable. The other marks a word store of the program counter, whose stored value is implementation defined.

The logic is combinational. The parameter `OUT_REG` adds one output register stage, which is cleared by reset. The access class is decoded into one of four named kinds, `ACC_LD_WORD`, `ACC_LD_BYTE`, `ACC_ST_WORD` and `ACC_ST_BYTE`, and every output is selected by that kind. The block holds no other state, so it has no state transitions.

Top module: `lsa_align_unit`

## Requirements
- R1: A word load (instr[20]=1, instr[22]=0) whose addr_lo is 0, 1, 2 or 3 returns mem_rdata rotated right by 0, 8, 16 or 24 bits on wb_data.
- R2: A byte load (instr[20]=1, instr[22]=1) returns byte lane addr_lo of mem_rdata (bits 8*addr_lo+7 down to 8*addr_lo) on wb_data, with bits 31:8 zero.
- R3: A word load whose destination field instr[15:12] equals 15 has bits 1:0 of the rotated result forced to zero.
- R4: A byte store (instr[20]=0, instr[22]=1) puts src_data[7:0] on all four lanes of st_data and sets only st_be[addr_lo].
- R5: A word store (instr[20]=0, instr[22]=0) puts src_data unchanged on st_data and sets all four bits of st_be.
- R6: For a load, st_data and st_be are zero. For a store, wb_data is zero.
- R7: unpred is set when the writeback bit instr[21] is 1 and the destination field instr[15:12] equals the base field instr[19:16].
- R8: unpred is set for a byte load or a byte store whose destination field is 15.
- R9: unpred is set for a word load whose destination field is 15 and whose addr_lo is not 0.
- R10: impl_def is set exactly for a word store whose source field instr[15:12] is 15.
- R11: Instruction bits other than instr[22:12] do not affect any output.
- R12: While req_valid is low, out_valid, wb_data, st_data, st_be, unpred and impl_def are all zero.
- R13: With OUT_REG=0 the outputs reflect the inputs in the same cycle that req_valid is high. With OUT_REG=1 they appear one clock later, and they are zero during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access and memory data are valid this cycle |
| instr | input | 32 | Load/store instruction word |
| addr_lo | input | 2 | Low bits of the effective address |
| mem_rdata | input | 32 | Raw little-endian word read from memory |
| src_data | input | 32 | Source register value for stores |
| out_valid | output | 1 | Outputs are valid |
| wb_data | output | 32 | Value to write back to the destination register |
| st_data | output | 32 | Store data with the bytes placed on their lanes |
| st_be | output | 4 | Per-lane store byte enables |
| unpred | output | 1 | Unpredictable register combination |
| impl_def | output | 1 | Word store of register 15 |

## Verification
A wrong kind decode or a wrong rotate amount shows up at once. In the combinational build it appears in the same cycle as req_valid; in the registered build it appears one edge later. The visible symptoms are a byte in the wrong position on wb_data, a missing or extra byte enable, or a data field that should be zero but is not. The bench sweeps every combination of load, writeback and byte bits against all four address offsets. It uses destination and base values 0, 3 and 15 and varies the unused instruction bits. Idle cycles are interleaved so that any value left over from the previous access is exposed.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    localparam int INSTR_W   = 32;
    localparam int REG_IDX_W = 4;
    localparam int POS_LOAD  = 20;
    localparam int POS_WBACK = 21;
    localparam int POS_BYTE  = 22;
    localparam int RD_LSB    = 12;
    localparam int RN_LSB    = 16;
    localparam logic [REG_IDX_W-1:0] PC_IDX = 4'd15;

    typedef enum logic [1:0] {
        ACC_LD_WORD = 2'd0,
        ACC_LD_BYTE = 2'd1,
        ACC_ST_WORD = 2'd2,
        ACC_ST_BYTE = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/lsa_decode.sv
module lsa_decode
    import lsa_pkg::*;
#(
    parameter int LANE_BITS = 2
) (
    input  logic                 valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [LANE_BITS-1:0] addr_lo,
    output acc_kind_e            kind,
    output logic [REG_IDX_W-1:0] rd,
    output logic                 unpred,
    output logic                 impl_def
);
    logic                 is_load;
    logic                 is_byte;
    logic                 wback;
    logic [REG_IDX_W-1:0] rn;
    logic                 kind_bad;
    logic                 unused_instr_bits;

    assign is_load = instr[POS_LOAD];
    assign is_byte = instr[POS_BYTE];
    assign wback   = instr[POS_WBACK];
    assign rd      = instr[RD_LSB +: REG_IDX_W];
    assign rn      = instr[RN_LSB +: REG_IDX_W];
    assign unused_instr_bits = ^{instr[INSTR_W-1:POS_BYTE+1], instr[RD_LSB-1:0]};

    always_comb begin
        unique case ({is_load, is_byte})
            2'b10:   kind = ACC_LD_WORD;
            2'b11:   kind = ACC_LD_BYTE;
            2'b00:   kind = ACC_ST_WORD;
            default: kind = ACC_ST_BYTE;
        endcase
    end

    always_comb begin
        kind_bad = 1'b0;
        impl_def = 1'b0;
        unique case (kind)
            ACC_LD_WORD: kind_bad = (rd == PC_IDX) && (addr_lo != '0);
            ACC_LD_BYTE: kind_bad = (rd == PC_IDX);
            ACC_ST_BYTE: kind_bad = (rd == PC_IDX);
            ACC_ST_WORD: impl_def = valid && (rd == PC_IDX);
            default:     kind_bad = 1'b0;
        endcase
        unpred = valid && (kind_bad || (wback && (rd == rn)));
    end
endmodule

// File: rtl/lsa_load_align.sv
module lsa_load_align
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          active,
    input  acc_kind_e                     kind,
    input  logic [REG_IDX_W-1:0]          rd,
    input  logic [$clog2(DATA_W/8)-1:0]   addr_lo,
    input  logic [DATA_W-1:0]             rdata,
    output logic [DATA_W-1:0]             wb_data
);
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);
    localparam logic [DATA_W-1:0] PC_KEEP = {{(DATA_W-LANE_BITS){1'b1}}, {LANE_BITS{1'b0}}};

    logic [7:0]          lane [LANES];
    logic [2*DATA_W-1:0] doubled;
    logic [DATA_W-1:0]   rotated;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = rdata[8*i +: 8];
    end

    assign doubled = {rdata, rdata};
    assign rotated = doubled[{addr_lo, 3'b000} +: DATA_W];

    always_comb begin
        wb_data = '0;
        if (active) begin
            unique case (kind)
                ACC_LD_WORD: wb_data = (rd == PC_IDX) ? (rotated & PC_KEEP) : rotated;
                ACC_LD_BYTE: wb_data = {{(DATA_W-8){1'b0}}, lane[addr_lo]};
                default:     wb_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          active,
    input  acc_kind_e                     kind,
    input  logic [$clog2(DATA_W/8)-1:0]   addr_lo,
    input  logic [DATA_W-1:0]             src,
    output logic [DATA_W-1:0]             st_data,
    output logic [DATA_W/8-1:0]           st_be
);
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            st_data[8*i +: 8] = 8'h00;
            st_be[i]          = 1'b0;
            if (active) begin
                unique case (kind)
                    ACC_ST_WORD: begin
                        st_data[8*i +: 8] = src[8*i +: 8];
                        st_be[i]          = 1'b1;
                    end
                    ACC_ST_BYTE: begin
                        st_data[8*i +: 8] = src[7:0];
                        st_be[i]          = (addr_lo == LANE_BITS'(i));
                    end
                    default: begin
                        st_data[8*i +: 8] = 8'h00;
                        st_be[i]          = 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/lsa_align_unit.sv
module lsa_align_unit
    import lsa_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit OUT_REG = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [INSTR_W-1:0]            instr,
    input  logic [$clog2(DATA_W/8)-1:0]   addr_lo,
    input  logic [DATA_W-1:0]             mem_rdata,
    input  logic [DATA_W-1:0]             src_data,
    output logic                          out_valid,
    output logic [DATA_W-1:0]             wb_data,
    output logic [DATA_W-1:0]             st_data,
    output logic [DATA_W/8-1:0]           st_be,
    output logic                          unpred,
    output logic                          impl_def
);
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);

    acc_kind_e            kind;
    logic [REG_IDX_W-1:0] rd;
    logic                 c_unpred;
    logic                 c_impl;
    logic [DATA_W-1:0]    c_wb;
    logic [DATA_W-1:0]    c_sd;
    logic [LANES-1:0]     c_be;

    lsa_decode #(.LANE_BITS(LANE_BITS)) u_decode (
        .valid    (req_valid),
        .instr    (instr),
        .addr_lo  (addr_lo),
        .kind     (kind),
        .rd       (rd),
        .unpred   (c_unpred),
        .impl_def (c_impl)
    );

    lsa_load_align #(.DATA_W(DATA_W)) u_load (
        .active  (req_valid),
        .kind    (kind),
        .rd      (rd),
        .addr_lo (addr_lo),
        .rdata   (mem_rdata),
        .wb_data (c_wb)
    );

    lsa_store_lane #(.DATA_W(DATA_W)) u_store (
        .active  (req_valid),
        .kind    (kind),
        .addr_lo (addr_lo),
        .src     (src_data),
        .st_data (c_sd),
        .st_be   (c_be)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                wb_data   <= '0;
                st_data   <= '0;
                st_be     <= '0;
                unpred    <= 1'b0;
                impl_def  <= 1'b0;
            end else begin
                out_valid <= req_valid;
                wb_data   <= c_wb;
                st_data   <= c_sd;
                st_be     <= c_be;
                unpred    <= c_unpred;
                impl_def  <= c_impl;
            end
        end

        a_r13_reg_follow: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> out_valid);
        a_r13_reg_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> (!out_valid && st_be == '0));
    end else begin : g_comb
        assign out_valid = req_valid;
        assign wb_data   = c_wb;
        assign st_data   = c_sd;
        assign st_be     = c_be;
        assign unpred    = c_unpred;
        assign impl_def  = c_impl;
    end

    a_r4_byte_be_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !instr[POS_LOAD] && instr[POS_BYTE]) |-> ($countones(c_be) == 1 && c_be[addr_lo]));
    a_r6_load_no_be: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && instr[POS_LOAD]) |-> (c_be == '0 && c_sd == '0));
    a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && instr[POS_LOAD] && instr[POS_BYTE]) |-> (c_wb[DATA_W-1:8] == '0));
    a_r3_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && instr[POS_LOAD] && !instr[POS_BYTE] && instr[RD_LSB +: REG_IDX_W] == PC_IDX)
        |-> (c_wb[LANE_BITS-1:0] == '0));
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (c_be == '0 && !c_unpred && !c_impl && c_wb == '0));
    a_r10_impl_word_store: assert property (@(posedge clk) disable iff (!rst_n)
        c_impl |-> (&c_be));
endmodule

// File: tb/lsa_align_unit_bench.sv
module lsa_align_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [1:0]  addr_lo = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] src_data = '0;

    logic        c_ov, r_ov, c_up, r_up, c_id, r_id;
    logic [31:0] c_wb, r_wb, c_sd, r_sd;
    logic [3:0]  c_be, r_be;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lsa_align_unit #(.DATA_W(32), .OUT_REG(1'b0)) u_lsa_align_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
        .addr_lo(addr_lo), .mem_rdata(mem_rdata), .src_data(src_data),
        .out_valid(c_ov), .wb_data(c_wb), .st_data(c_sd), .st_be(c_be),
        .unpred(c_up), .impl_def(c_id));

    lsa_align_unit #(.DATA_W(32), .OUT_REG(1'b1)) u_lsa_align_unit_reg (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
        .addr_lo(addr_lo), .mem_rdata(mem_rdata), .src_data(src_data),
        .out_valid(r_ov), .wb_data(r_wb), .st_data(r_sd), .st_be(r_be),
        .unpred(r_up), .impl_def(r_id));

    logic        e_ov, e_up, e_id;
    logic [31:0] e_wb, e_sd;
    logic [3:0]  e_be;
    string       t_wb, t_sd, t_up, t_id;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic v, input logic ld, input logic wbk, input logic byt,
                         input logic [3:0] rd, input logic [3:0] rn, input logic [1:0] a,
                         input logic [31:0] rdat, input logic [31:0] src);
        logic [63:0] dbl;
        dbl = {rdat, rdat};
        e_ov = v; e_wb = '0; e_sd = '0; e_be = '0; e_up = 1'b0; e_id = 1'b0;
        t_wb = "R6"; t_sd = "R6"; t_up = "R7"; t_id = "R10";
        if (v) begin
            if (ld && !byt) begin
                e_wb = dbl[8*a +: 32];
                t_wb = "R1";
                if (rd == 4'd15) begin e_wb = e_wb & 32'hFFFF_FFFC; t_wb = "R3"; end
            end else if (ld && byt) begin
                e_wb = {24'h0, dbl[8*a +: 8]};
                t_wb = "R2";
            end else if (!ld && byt) begin
                e_sd = {4{src[7:0]}}; e_be = 4'b0001 << a; t_sd = "R4";
            end else begin
                e_sd = src; e_be = 4'hF; t_sd = "R5";
            end
            if (byt && rd == 4'd15) t_up = "R8";
            if (ld && !byt && rd == 4'd15 && a != 2'd0) t_up = "R9";
            e_up = (wbk && rd == rn) || (byt && rd == 4'd15) || (ld && !byt && rd == 4'd15 && a != 2'd0);
            e_id = !ld && !byt && rd == 4'd15;
        end else begin
            t_wb = "R12"; t_sd = "R12"; t_up = "R12"; t_id = "R12";
        end
    endtask

    task automatic compare(input bit regd);
        string p;
        p = regd ? " R13 reg" : " R13 comb";
        chk("R12", {"valid", p}, regd ? {31'h0, r_ov} : {31'h0, c_ov}, {31'h0, e_ov});
        chk(t_wb, {"wb_data", p}, regd ? r_wb : c_wb, e_wb);
        chk(t_sd, {"st_data", p}, regd ? r_sd : c_sd, e_sd);
        chk(t_sd, {"st_be", p}, regd ? {28'h0, r_be} : {28'h0, c_be}, {28'h0, e_be});
        chk(t_up, {"unpred", p}, regd ? {31'h0, r_up} : {31'h0, c_up}, {31'h0, e_up});
        chk(t_id, {"impl_def", p}, regd ? {31'h0, r_id} : {31'h0, c_id}, {31'h0, e_id});
    endtask

    task automatic apply(input logic v, input logic [31:0] junk, input logic ld, input logic wbk,
                         input logic byt, input logic [3:0] rd, input logic [3:0] rn,
                         input logic [1:0] a, input logic [31:0] rdat, input logic [31:0] src);
        @(negedge clk);
        req_valid = v;
        instr = junk;
        instr[20] = ld; instr[21] = wbk; instr[22] = byt;
        instr[15:12] = rd; instr[19:16] = rn;
        addr_lo = a; mem_rdata = rdat; src_data = src;
        model(v, ld, wbk, byt, rd, rn, a, rdat, src);
        #1 compare(1'b0);
        @(posedge clk);
        #1 compare(1'b1);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] junk;
        int step;
        step = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R13", "reset reg valid", {31'h0, r_ov}, 32'h0);
        chk("R13", "reset reg wb", r_wb, 32'h0);
        chk("R13", "reset reg be", {28'h0, r_be}, 32'h0);
        chk("R12", "idle comb be", {28'h0, c_be}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 8; k++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int di = 0; di < 3; di++) begin
                        for (int ni = 0; ni < 3; ni++) begin
                            logic [3:0] rdv, rnv;
                            logic [31:0] rdat, src;
                            rdv = (di == 0) ? 4'd0 : (di == 1) ? 4'd3 : 4'd15;
                            rnv = (ni == 0) ? 4'd0 : (ni == 1) ? 4'd3 : 4'd15;
                            rdat = (p == 0) ? 32'hA1B2_C3D4 : 32'h807F_01FE;
                            src  = (p == 0) ? 32'h5E6F_7A8B : 32'hC300_0096;
                            step++;
                            junk = step * 32'h9E37_79B9;
                            // R11: junk fills all instruction bits outside 22:12
                            apply(1'b1, junk, k[0], k[1], k[2], rdv, rnv, a[1:0], rdat, src);
                            if ((step % 7) == 0)
                                apply(1'b0, ~junk, k[0], k[1], k[2], rdv, rnv, a[1:0], ~rdat, ~src);
                        end
                    end
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule